// File: doc/BRIEF.md
# DMA Channel Interrupt Coalescing Registers

This block is the control and status register file of one DMA channel. It also decides when the channel raises its interrupt. A simple write/read port reaches four word registers: control, status, current descriptor and tail descriptor. The descriptor engine sends a one-cycle pulse each time a packet finishes. The block counts these pulses against a threshold taken from the control register.

A second counter measures inactivity after the last completion. It decrements on an external prescaled tick enable, so the block needs no knowledge of the clock frequency. The block decodes run/stop and soft reset, and it keeps the halted and idle flags. The completion interrupt and the delay interrupt are cleared by writing 1 to them. The single interrupt line is each pending bit ANDed with its enable bit in the control register, then ORed together. A status read also shows the live completion count and the live delay count.

Top module: `dma_irq_coalesce`

## Requirements
- R1: Byte offsets on `addr_i` select the registers: 0x00 control, 0x04 status, 0x08 current descriptor, 0x10 tail descriptor. Both descriptor registers hold all 32 written bits. Any other offset, including an offset that is not word-aligned, reads 0 and ignores writes.
- R2: Control bit 1 always reads back as 1, whatever value was written.
- R3: After `rst_ni` the control register reads 0x00010002 and the status register reads 0x00010001. `irq_o` is low.
- R4: `irq_o` is the OR over bits 14:12 of (status AND control).
- R5: In status, writing 1 to one of bits 14:12 clears that bit and writing 0 leaves it unchanged. Status bits 15 and 11:0 take the written value.
- R6: A soft reset replaces the whole control register with 0x00010006 and the status bits 15:0 with 0x0001. It also reloads the completion count with 1 and clears the delay count. A soft reset happens on any control write in which bit 2 is set, either in the written data or still pending in the register.
- R7: Every control write reloads the completion count from control bits 23:16. Each `pkt_done_i` pulse decrements the count. When the count steps from 1 to 0, status bit 12 is set and the count reloads from the threshold. A threshold of 0 behaves as 256.
- R8: If control bits 31:24 are nonzero, each `pkt_done_i` loads the delay count with that value. If the field is 0, a completion leaves the delay count unchanged. A `tick_i` pulse decrements a nonzero delay count. When the delay count steps from 1 to 0, status bit 13 is set and the completion count reloads from the threshold.
- R9: A status read returns the live completion count in bits 23:16 and the live delay count in bits 31:24.
- R10: A control write with bit 0 set clears the halted flag (status bit 0) and the idle flag (status bit 1). A write that is a soft reset leaves the block halted instead.
- R11: The soft-reset bit (control bit 2) stays set until the control register is read. That read returns the bit as 1 and then clears it.
- R12: A write to the tail descriptor register clears the idle flag.
- R13: If a control write and `pkt_done_i` arrive in the same cycle, the reload wins and the packet is not counted. If `pkt_done_i` and `tick_i` arrive in the same cycle, the delay restart wins and no delay interrupt fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (a control read clears the soft-reset bit) |
| addr_i | input | 6 | Byte offset within the channel window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| pkt_done_i | input | 1 | One-cycle pulse per completed packet |
| tick_i | input | 1 | Prescaled tick enable for the delay counter |
| irq_o | output | 1 | Channel interrupt |

## Verification
The threshold is swept from 1 to 6 and also set to 0. At every packet the bench checks both the interrupt line and the count field, which separates an off-by-one reload from a wrong threshold source, and the threshold of 0 shows whether the count wraps to 256. The delay value is swept from 1 to 5 under a tick sequence, and a delay of 0 is also tried. All eight patterns on the write-1-to-clear bits are applied with both interrupts pending, which tells clear-on-1 apart from overwrite. Further sequences exercise each same-cycle conflict and the soft reset that stays pending until the control register is read.

// File: rtl/dma_coal_pkg.sv
package dma_coal_pkg;
  localparam int DATA_W   = 32;
  localparam int FLD_W    = 8;
  // word indices (byte offset / 4)
  localparam int IDX_CTRL = 0;
  localparam int IDX_STAT = 1;
  localparam int IDX_CUR  = 2;
  localparam int IDX_TAIL = 4;
  // control bits
  localparam int CB_RUN   = 0;
  localparam int CB_TAIL  = 1;
  localparam int CB_SRST  = 2;
  localparam int THR_LSB  = 16;
  localparam int DLY_LSB  = 24;
  // status bits
  localparam int SB_HALT  = 0;
  localparam int SB_IDLE  = 1;
  localparam int SB_IOC   = 12;
  localparam int SB_DLY   = 13;
  localparam int IRQ_LSB  = 12;
  localparam int IRQ_MSB  = 14;
  localparam logic [DATA_W-1:0] CTRL_RST = 32'h0001_0002;
  localparam logic [DATA_W-1:0] CTRL_SRST = 32'h0001_0006;
  localparam logic [15:0]       STAT_RST = 16'h0001;
endpackage

// File: rtl/dma_coal_thr.sv
module dma_coal_thr #(
  parameter int CNT_W   = 8,
  parameter int RST_VAL = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             hit_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  assign hit_o = dec_i && !load_i && (cnt_q == ONE);
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= CNT_W'(RST_VAL);
    else if (load_i)   cnt_q <= load_val_i;
    else if (hit_o)    cnt_q <= load_val_i;
    else if (dec_i)    cnt_q <= cnt_q - ONE;  // 0 wraps: threshold 0 acts as 2**CNT_W
  end

  AST_THR_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |=> cnt_o == $past(load_val_i)); // R7
  AST_THR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !load_i && cnt_o != ONE) |=> cnt_o == $past(cnt_o) - ONE); // R7
endmodule

// File: rtl/dma_coal_dly.sv
module dma_coal_dly #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] restart_val_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             fire_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  assign fire_o = tick_i && !clear_i && !restart_i && (cnt_q == ONE);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (clear_i)                     cnt_q <= '0;
    else if (restart_i)                   cnt_q <= restart_val_i;
    else if (tick_i && cnt_q != '0)       cnt_q <= cnt_q - ONE;
  end

  AST_DLY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !restart_i && !clear_i) |=> $stable(cnt_o)); // R8
  AST_DLY_EXPIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_o |=> cnt_o == '0); // R8
  AST_DLY_RESTART_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restart_i && !clear_i) |=> cnt_o == $past(restart_val_i)); // R13
endmodule

// File: rtl/dma_irq_coalesce.sv
module dma_irq_coalesce
  import dma_coal_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              pkt_done_i,
  input  logic              tick_i,
  output logic              irq_o
);
  localparam int IDX_W = ADDR_W - 2;

  logic [DATA_W-1:0] ctrl_q, cur_q, tail_q;
  logic [15:0]       stat_q, stat_d;
  logic [IDX_W-1:0]  idx;
  logic              aligned;
  logic              sel_ctrl, sel_stat, sel_cur, sel_tail;
  logic              wr_ctrl, wr_stat, wr_cur, wr_tail, rd_ctrl;
  logic              srst_req;
  logic [FLD_W-1:0]  thr_val, thr_cnt, dly_cnt, dly_cfg;
  logic              thr_hit, dly_fire;

  assign idx      = addr_i[ADDR_W-1:2];
  assign aligned  = (addr_i[1:0] == 2'b00);
  assign sel_ctrl = aligned && (idx == IDX_W'(IDX_CTRL));
  assign sel_stat = aligned && (idx == IDX_W'(IDX_STAT));
  assign sel_cur  = aligned && (idx == IDX_W'(IDX_CUR));
  assign sel_tail = aligned && (idx == IDX_W'(IDX_TAIL));

  assign wr_ctrl  = wr_en_i && sel_ctrl;
  assign wr_stat  = wr_en_i && sel_stat;
  assign wr_cur   = wr_en_i && sel_cur;
  assign wr_tail  = wr_en_i && sel_tail;
  assign rd_ctrl  = rd_en_i && sel_ctrl;

  // a pending reset bit re-triggers reset on every control write
  assign srst_req = wr_ctrl && (wdata_i[CB_SRST] || ctrl_q[CB_SRST]);

  assign dly_cfg  = ctrl_q[DLY_LSB +: FLD_W];
  assign thr_val  = srst_req ? FLD_W'(1)
                  : wr_ctrl  ? wdata_i[THR_LSB +: FLD_W]
                  :            ctrl_q[THR_LSB +: FLD_W];

  dma_coal_thr #(.CNT_W(FLD_W), .RST_VAL(1)) u_thr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (wr_ctrl || dly_fire),
    .load_val_i (thr_val),
    .dec_i      (pkt_done_i),
    .cnt_o      (thr_cnt),
    .hit_o      (thr_hit)
  );

  dma_coal_dly #(.CNT_W(FLD_W)) u_dly (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .clear_i       (srst_req),
    .restart_i     (pkt_done_i && (dly_cfg != '0)),
    .restart_val_i (dly_cfg),
    .tick_i        (tick_i),
    .cnt_o         (dly_cnt),
    .fire_o        (dly_fire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= CTRL_RST;
    end else if (wr_ctrl) begin
      ctrl_q <= srst_req ? CTRL_SRST : (wdata_i | (DATA_W'(1) << CB_TAIL));
    end else if (rd_ctrl) begin
      ctrl_q[CB_SRST] <= 1'b0;
    end
  end

  always_comb begin
    stat_d = stat_q;
    if (srst_req) begin
      stat_d = STAT_RST;
    end else begin
      if (wr_stat) begin
        stat_d = wdata_i[15:0];
        stat_d[IRQ_MSB:IRQ_LSB] = stat_q[IRQ_MSB:IRQ_LSB] & ~wdata_i[IRQ_MSB:IRQ_LSB];
      end
      if (wr_ctrl && wdata_i[CB_RUN]) begin
        stat_d[SB_HALT] = 1'b0;
        stat_d[SB_IDLE] = 1'b0;
      end
      if (wr_tail)  stat_d[SB_IDLE] = 1'b0;
      if (thr_hit)  stat_d[SB_IOC]  = 1'b1;
      if (dly_fire) stat_d[SB_DLY]  = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= STAT_RST;
      cur_q  <= '0;
      tail_q <= '0;
    end else begin
      stat_q <= stat_d;
      if (wr_cur)  cur_q  <= wdata_i;
      if (wr_tail) tail_q <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel_ctrl)      rdata_o = ctrl_q;
    else if (sel_stat) rdata_o = {dly_cnt, thr_cnt, stat_q};
    else if (sel_cur)  rdata_o = cur_q;
    else if (sel_tail) rdata_o = tail_q;
  end

  assign irq_o = |(stat_q[IRQ_MSB:IRQ_LSB] & ctrl_q[IRQ_MSB:IRQ_LSB]);

  AST_TAIL_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_ctrl |-> rdata_o[CB_TAIL]); // R2
  AST_W1C_IOC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stat && wdata_i[SB_IOC] && !thr_hit) |=> !stat_q[SB_IOC]); // R5
  AST_SRST_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_req |=> (stat_q == STAT_RST && ctrl_q == CTRL_SRST && thr_cnt == FLD_W'(1))); // R6
  AST_SRST_BLOCKS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_req |=> stat_q[SB_HALT]); // R10
  AST_SRST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q[CB_SRST] && !rd_ctrl && !wr_ctrl) |=> ctrl_q[CB_SRST]); // R11
  AST_TAIL_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_tail |=> !stat_q[SB_IDLE]); // R12
endmodule

// File: tb/dma_irq_coalesce_tb_top.sv
module dma_irq_coalesce_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0, pkt = 1'b0, tick = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int          vectors = 0;
  int          fails = 0;

  localparam logic [5:0] A_CTRL = 6'h00, A_STAT = 6'h04, A_CUR = 6'h08, A_TAIL = 6'h10;

  always #4 clk = ~clk;

  dma_irq_coalesce dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .pkt_done_i(pkt), .tick_i(tick), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a; #1; d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic pulse_pkt();
    @(negedge clk); pkt = 1'b1;
    @(negedge clk); pkt = 1'b0;
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic        any_irq;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R3 reset state
    chk("R3 irq", {31'b0, irq}, 32'h0);
    rd(A_CTRL, v); chk("R3 ctrl", v, 32'h0001_0002);
    rd(A_STAT, v); chk("R3 stat", v, 32'h0001_0001);

    // R1 decode
    wr(A_CUR, 32'hDEAD_BEE0); wr(A_TAIL, 32'h1234_5670);
    rd(A_CUR, v);  chk("R1 cur", v, 32'hDEAD_BEE0);
    rd(A_TAIL, v); chk("R1 tail", v, 32'h1234_5670);
    rd(6'h0C, v);  chk("R1 hole", v, 32'h0);
    rd(6'h14, v);  chk("R1 hole2", v, 32'h0);
    rd(6'h01, v);  chk("R1 misaligned", v, 32'h0);

    // R2 tail-mode bit
    wr(A_CTRL, 32'h0);
    rd(A_CTRL, v); chk("R2 ctrl", v, 32'h0000_0002);

    // R5 plain bits, R10 run
    wr(A_STAT, 32'h0000_8A03);
    rd(A_STAT, v); chk("R5 plain", v, 32'h0000_8A03);
    wr(A_CTRL, 32'h1);
    rd(A_STAT, v); chk("R10 run", v, 32'h0000_8A00);

    // R12 tail clears idle
    wr(A_STAT, 32'h2);
    rd(A_STAT, v); chk("R12 idle set", v, 32'h2);
    wr(A_TAIL, 32'h40);
    rd(A_STAT, v); chk("R12 idle clr", v, 32'h0);

    // R7 / R9 threshold sweep
    for (int thr = 1; thr <= 6; thr++) begin
      wr(A_CTRL, (32'(thr) << 16) | 32'h1001);
      wr(A_STAT, 32'h7000);
      for (int k = 1; k <= thr; k++) begin
        pulse_pkt();
        chk("R7 irq", {31'b0, irq}, (k == thr) ? 32'h1 : 32'h0);
        rd(A_STAT, v);
        chk("R9 count", v, (k == thr) ? ((32'(thr) << 16) | 32'h1000) : (32'(thr - k) << 16));
      end
    end
    // R7 threshold 0 acts as 256
    wr(A_CTRL, 32'h0000_1001);
    wr(A_STAT, 32'h7000);
    any_irq = 1'b0;
    for (int k = 1; k <= 255; k++) begin
      pulse_pkt();
      any_irq = any_irq | irq;
    end
    chk("R7 thr0 early", {31'b0, any_irq}, 32'h0);
    pulse_pkt();
    chk("R7 thr0 irq", {31'b0, irq}, 32'h1);
    rd(A_STAT, v); chk("R7 thr0 stat", v, 32'h0000_1000);

    // R8 delay sweep
    for (int d = 1; d <= 5; d++) begin
      wr(A_CTRL, (32'(d) << 24) | (32'd2 << 16) | 32'h2001);
      wr(A_STAT, 32'h7000);
      pulse_pkt();
      rd(A_STAT, v); chk("R8 load", v, (32'(d) << 24) | (32'd1 << 16));
      for (int j = 1; j < d; j++) begin
        pulse_tick();
        chk("R8 quiet", {31'b0, irq}, 32'h0);
      end
      rd(A_STAT, v); chk("R8 last", v, (32'd1 << 24) | (32'd1 << 16));
      pulse_tick();
      chk("R8 irq", {31'b0, irq}, 32'h1);
      rd(A_STAT, v); chk("R8 fire", v, (32'd2 << 16) | 32'h2000);
    end
    // R8 delay 0 leaves counter idle
    wr(A_CTRL, (32'd3 << 16) | 32'h2001);
    wr(A_STAT, 32'h7000);
    pulse_pkt();
    repeat (4) pulse_tick();
    chk("R8 dly0 irq", {31'b0, irq}, 32'h0);
    rd(A_STAT, v); chk("R8 dly0 stat", v, 32'd2 << 16);

    // R4 enable mask
    wr(A_CTRL, (32'd1 << 16) | 32'h1);
    wr(A_STAT, 32'h7000);
    pulse_pkt();
    chk("R4 masked", {31'b0, irq}, 32'h0);
    rd(A_STAT, v); chk("R4 pending", v, (32'd1 << 16) | 32'h1000);
    wr(A_CTRL, (32'd1 << 16) | 32'h2001);
    chk("R4 other en", {31'b0, irq}, 32'h0);
    wr(A_CTRL, (32'd1 << 16) | 32'h1001);
    chk("R4 enabled", {31'b0, irq}, 32'h1);

    // R5 write-1-to-clear sweep
    for (int p = 0; p < 8; p++) begin
      wr(A_CTRL, (32'd1 << 24) | (32'd1 << 16) | 32'h1);
      wr(A_STAT, 32'h7000);
      pulse_pkt();
      pulse_tick();
      wr(A_STAT, 32'(p) << 12);
      rd(A_STAT, v);
      chk("R5 w1c", v, (32'd1 << 16) | (32'((~p) & 3) << 12));
    end

    // R6 / R11 soft reset
    wr(A_CTRL, 32'h4);
    rd(A_CTRL, v); chk("R11 visible", v, 32'h0001_0006);
    rd(A_CTRL, v); chk("R11 cleared", v, 32'h0001_0002);
    rd(A_STAT, v); chk("R6 stat", v, 32'h0001_0001);

    // R10 run blocked while reset pending
    wr(A_CTRL, 32'h4);
    wr(A_CTRL, 32'h1);
    rd(A_STAT, v); chk("R10 blocked", v, 32'h0001_0001);
    rd(A_CTRL, v); chk("R6 rewrite", v, 32'h0001_0006);
    wr(A_CTRL, 32'h1);
    rd(A_STAT, v); chk("R10 after read", v, 32'h0000_0000);

    // R13 write vs packet
    wr(A_CTRL, (32'd2 << 16) | 32'h1);
    @(negedge clk); wr_en = 1'b1; addr = A_CTRL; wdata = (32'd2 << 16) | 32'h1; pkt = 1'b1;
    @(negedge clk); wr_en = 1'b0; pkt = 1'b0;
    rd(A_STAT, v); chk("R13 write wins", v, 32'd2 << 16);
    // R13 restart vs tick
    wr(A_CTRL, (32'd3 << 24) | (32'd5 << 16) | 32'h1);
    wr(A_STAT, 32'h7000);
    pulse_pkt();
    pulse_tick(); pulse_tick();
    @(negedge clk); pkt = 1'b1; tick = 1'b1;
    @(negedge clk); pkt = 1'b0; tick = 1'b0;
    rd(A_STAT, v); chk("R13 restart wins", v, (32'd3 << 24) | (32'd3 << 16));

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule